// File: doc/BRIEF.md
# SONET Frame Alignment State Machine

This block decides whether a 32-bit-per-cycle STS-48 receive stream is aligned to its frames. Outside logic searches for the framing bytes and counts rows and columns. It supplies two strobes. `frm_tick` marks the cycle where the framing word is expected. `pat_ok` reports whether the expected pattern is present on the current word. The pattern is four 0xF6 bytes followed by four 0x28 bytes, which spans two consecutive 32-bit words. The state machine takes one decision per frame, on the cycle where `frm_tick` is high, and ignores `pat_ok` in every other cycle. An STS-48 frame is 9720 words long. The bench uses a much shorter tick period, because the counters are outside this block.

There are six states:

- SEARCH (code 0): hunting for the pattern; the out-of-frame alarm is raised.
- NEWF (code 1): one good frame has been seen and is waiting for confirmation.
- INF (code 2): aligned.
- HOLD1, HOLD2 and HOLD3 (codes 3, 4 and 5): tolerate one, two and three consecutive errored frames.

The transitions are named as follows:

- *acquire*: SEARCH to NEWF.
- *fast-acquire*: SEARCH to INF, taken in fast mode.
- *confirm*: NEWF to INF.
- *reject*: NEWF to SEARCH.
- *slip*: INF to HOLD1, HOLD1 to HOLD2, and HOLD2 to HOLD3.
- *recover*: any HOLD state to INF.
- *lose*: HOLD3 to SEARCH.

Top module: `sonet_frame_sync`

## Requirements
- R1: After reset the state code is 0 (SEARCH), `oof_alarm` is 1 and `in_frame` is 0.
- R2: With `fast_mode` low, a tick with `pat_ok` high moves SEARCH to NEWF (code 1), and a second such tick moves NEWF to INF (code 2).
- R3: With `fast_mode` high, a tick with `pat_ok` high moves SEARCH directly to INF.
- R4: A tick with `pat_ok` low while in NEWF returns the machine to SEARCH.
- R5: Ticks with `pat_ok` low step INF to HOLD1 (code 3), then to HOLD2 (code 4), then to HOLD3 (code 5). A fourth such tick, taken from HOLD3, returns the machine to SEARCH.
- R6: A tick with `pat_ok` high in HOLD1, HOLD2 or HOLD3 returns the machine to INF.
- R7: `oof_alarm` is 1 only in SEARCH. `in_frame` is 1 in INF and in the three HOLD states, and 0 in SEARCH and NEWF.
- R8: In a cycle with `frm_tick` low, the state does not change, whatever the value of `pat_ok`.
- R9: `fast_mode` does not shorten loss of frame: with it high, four errored ticks are still needed to leave INF.
- R10: A tick with `pat_ok` low keeps SEARCH in SEARCH, and a tick with `pat_ok` high keeps INF in INF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_tick | input | 1 | Marks the expected framing-word cycle |
| pat_ok | input | 1 | Framing pattern detected on this word |
| fast_mode | input | 1 | One-frame acquisition when high |
| oof_alarm | output | 1 | Out-of-frame alarm |
| in_frame | output | 1 | Alignment held (INF or HOLD states) |
| state_o | output | 3 | Current state code |

## Verification
The bench builds the block with its package defaults: a 3-bit state code and six states. This lets the bench walk every transition of the graph in a few dozen cycles. Ticks are spaced a few cycles apart rather than 9720 words apart. The idle cycles between ticks carry `pat_ok` toggling, which brings the ignore-off-tick rule within reach. The bench then switches to fast mode, which exercises fast acquisition together with a full four-frame loss.

// File: rtl/sfs_pkg.sv
package sfs_pkg;
    localparam int unsigned STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_SEARCH = 3'd0,
        ST_NEWF   = 3'd1,
        ST_INF    = 3'd2,
        ST_HOLD1  = 3'd3,
        ST_HOLD2  = 3'd4,
        ST_HOLD3  = 3'd5
    } sfs_state_e;
endpackage

// File: rtl/sfs_event.sv
module sfs_event (
    input  logic tick,
    input  logic pat,
    output logic good_ev,
    output logic bad_ev
);
    // A frame decision exists only on the tick cycle.
    always_comb begin
        good_ev = tick & pat;
        bad_ev  = tick & ~pat;
    end
endmodule

// File: rtl/sfs_fsm.sv
module sfs_fsm
    import sfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               good_ev,
    input  logic               bad_ev,
    input  logic               fast,
    output logic               oof,
    output logic               locked,
    output logic [STATE_W-1:0] code
);
    sfs_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SEARCH: if (good_ev) nxt = fast ? ST_INF : ST_NEWF;
            ST_NEWF: begin
                if (good_ev)     nxt = ST_INF;
                else if (bad_ev) nxt = ST_SEARCH;
            end
            ST_INF:    if (bad_ev) nxt = ST_HOLD1;
            ST_HOLD1: begin
                if (good_ev)     nxt = ST_INF;
                else if (bad_ev) nxt = ST_HOLD2;
            end
            ST_HOLD2: begin
                if (good_ev)     nxt = ST_INF;
                else if (bad_ev) nxt = ST_HOLD3;
            end
            ST_HOLD3: begin
                if (good_ev)     nxt = ST_INF;
                else if (bad_ev) nxt = ST_SEARCH;
            end
            default: nxt = ST_SEARCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_SEARCH;
        else        state <= nxt;
    end

    always_comb begin
        oof    = 1'b0;
        locked = 1'b0;
        unique case (state)
            ST_SEARCH: oof = 1'b1;
            ST_NEWF:   ;
            ST_INF, ST_HOLD1, ST_HOLD2, ST_HOLD3: locked = 1'b1;
            default:   oof = 1'b1;
        endcase
        code = state;
    end

    // R2
    acquire_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state == ST_SEARCH) && $past(good_ev) && !$past(fast))
        |-> (state == ST_NEWF));
    // R3
    fast_acquire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state == ST_SEARCH) && $past(good_ev) && $past(fast))
        |-> (state == ST_INF));
    // R5
    lose_after_four_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(state == ST_HOLD3) && $past(bad_ev))
        |-> (state == ST_SEARCH));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(good_ev) && !$past(bad_ev)) |-> $stable(state));
    // R7
    alarm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oof) |-> (state == ST_NEWF || state == ST_INF));
endmodule

// File: rtl/sonet_frame_sync.sv
module sonet_frame_sync
    import sfs_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frm_tick,
    input  logic               pat_ok,
    input  logic               fast_mode,
    output logic               oof_alarm,
    output logic               in_frame,
    output logic [STATE_W-1:0] state_o
);
    logic good_ev, bad_ev;

    sfs_event u_event (
        .tick    (frm_tick),
        .pat     (pat_ok),
        .good_ev (good_ev),
        .bad_ev  (bad_ev)
    );

    sfs_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .good_ev (good_ev),
        .bad_ev  (bad_ev),
        .fast    (fast_mode),
        .oof     (oof_alarm),
        .locked  (in_frame),
        .code    (state_o)
    );
endmodule

// File: tb/test_sonet_frame_sync.sv
module test_sonet_frame_sync;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frm_tick = 1'b0;
    logic       pat_ok = 1'b0;
    logic       fast_mode = 1'b0;
    logic       oof_alarm, in_frame;
    logic [2:0] state_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [2:0] model = 3'd0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    sonet_frame_sync i_sonet_frame_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .frm_tick  (frm_tick),
        .pat_ok    (pat_ok),
        .fast_mode (fast_mode),
        .oof_alarm (oof_alarm),
        .in_frame  (in_frame),
        .state_o   (state_o)
    );

    function automatic logic [2:0] ref_next(logic [2:0] s, logic t, logic p, logic f);
        if (!t) return s;
        case (s)
            3'd0: return p ? (f ? 3'd2 : 3'd1) : 3'd0;
            3'd1: return p ? 3'd2 : 3'd0;
            3'd2: return p ? 3'd2 : 3'd3;
            3'd3: return p ? 3'd2 : 3'd4;
            3'd4: return p ? 3'd2 : 3'd5;
            default: return p ? 3'd2 : 3'd0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expected state.
    task automatic step(logic t, logic p, string tag);
        @(negedge clk);
        frm_tick = t;
        pat_ok = p;
        @(posedge clk);
        #1;
        model = ref_next(model, t, p, fast_mode);
        exp_q.push_back(model);
        tag_q.push_back(tag);
    endtask

    // Monitor: compare away from the clock edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [2:0] e;
            string tg;
            e = exp_q.pop_front();
            tg = tag_q.pop_front();
            check(tg, state_o, e);
            check("R7 oof", oof_alarm, (e == 3'd0));
            check("R7 in_frame", in_frame, (e >= 3'd2));
        end
    end

    initial begin
        #(20 * 200000);
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 state", state_o, 0);
        check("R1 oof", oof_alarm, 1);
        check("R1 in_frame", in_frame, 0);
        rst_n = 1'b1;

        step(0, 1, "R8");
        step(1, 0, "R10");
        step(1, 1, "R2");
        step(0, 0, "R8");
        step(1, 0, "R4");
        step(1, 1, "R2");
        step(0, 1, "R8");
        step(1, 1, "R2");
        step(1, 1, "R10");
        step(1, 0, "R5");
        step(1, 1, "R6");
        step(1, 0, "R5");
        step(1, 0, "R5");
        step(0, 1, "R8");
        step(1, 1, "R6");
        step(1, 0, "R5");
        step(1, 0, "R5");
        step(1, 0, "R5");
        step(0, 1, "R8");
        step(1, 1, "R6");
        step(1, 0, "R5");
        step(1, 0, "R5");
        step(1, 0, "R5");
        step(0, 0, "R8");
        step(1, 0, "R5");

        @(negedge clk);
        fast_mode = 1'b1;
        step(1, 1, "R3");
        step(1, 0, "R9");
        step(0, 1, "R8");
        step(1, 0, "R9");
        step(1, 0, "R9");
        step(1, 0, "R9");
        step(1, 1, "R3");
        step(1, 1, "R10");

        @(negedge clk);
        frm_tick = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule